// File: doc/BRIEF.md
# Pointer-Indexed Register Load Unit

This unit carries out a family of three-byte load instructions. Each one fills a 16-bit destination register (BC, DE, IX or IY) from two consecutive memory bytes. Instruction bytes arrive one at a time on a byte-wide fetch port. The first byte must be the prefix 0x6D. The second is a selector whose upper nibble names both the destination and one of four 32-bit pointer registers. The third is a signed 8-bit displacement.

The unit adds the sign-extended displacement to the chosen pointer. It checks whether the upper half of the sum is all ones. If so, the address is logical and is flagged for translation. If not, it is physical: it is cut to 20 or 24 bits and passes untranslated. The unit then issues two byte reads, one after the other, on a request/response memory port. When both bytes have arrived it writes the 16-bit result in a single cycle.

A selector with a nonzero low nibble is reported as illegal and makes no memory access.

Top module: `ptr_load_unit`

## Requirements
- R1: While waiting for an instruction start, any accepted fetch byte other than 0x6D is dropped. It starts nothing and raises no flag.
- R2: In the selector's upper nibble, bits [7:6] pick the destination and bits [5:4] pick the pointer. The destination code is 0=BC, 1=DE, 2=IX, 3=IY and is output on wr_dst_o. The pointer code 0..3 indexes ptr_file_i.
- R3: When the selector's low nibble is nonzero, illegal_o is high for exactly the one cycle after the selector is accepted. No memory request follows, and the unit goes back to waiting for a prefix.
- R4: The effective address is the pointer plus the sign-extended displacement, modulo 2^32. The pointer and alt_i are sampled in the cycle the displacement byte is accepted.
- R5: When the upper 16 bits of an access address are all ones, mem_req_xlate_o is 1 and mem_req_addr_o carries all 32 bits unchanged.
- R6: Otherwise mem_req_xlate_o is 0 and mem_req_addr_o is the address masked to its low 20 bits (phys24_i=0) or its low 24 bits (phys24_i=1).
- R7: The first read goes to the effective address and the second to the effective address plus one, with 32-bit wrap. Each read is classified on its own. The second request is not issued until the first response has been accepted.
- R8: A pending request holds mem_req_valid_o high, with a stable address and flag, until mem_req_ready_i is seen.
- R9: In the cycle after the second response is accepted, wr_en_o and done_o are high together for exactly one cycle. wr_data_o holds the second byte in bits [15:8] and the first byte in bits [7:0].
- R10: For BC and DE, wr_alt_o equals the sampled alt_i. For IX and IY, wr_alt_o is always 0.
- R11: A response strobe is ignored unless a read is outstanding. fetch_ready_o is low from the start of the memory phase until the write.
- R12: During and right after reset there is no request and no write, illegal_o is low and fetch_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Instruction byte valid |
| fetch_byte_i | input | 8 | Instruction byte |
| fetch_ready_o | output | 1 | Unit can take an instruction byte |
| alt_i | input | 1 | Alternate-register-set modifier |
| phys24_i | input | 1 | Physical width: 1 = 24 bits, 0 = 20 bits |
| ptr_file_i | input | 4x32 | Pointer registers, index 0..3 |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 32 | Read address |
| mem_req_xlate_o | output | 1 | Address is logical and needs translation |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 8 | Read data byte |
| wr_en_o | output | 1 | Destination write strobe |
| wr_dst_o | output | 2 | Destination code |
| wr_alt_o | output | 1 | Write targets the alternate copy |
| wr_data_o | output | 16 | Value written |
| done_o | output | 1 | Instruction completed |
| illegal_o | output | 1 | Illegal selector seen |

## Verification
A corrupted latched effective address shows up on the very first request as a wrong address or a wrong translation flag. The bench changes the pointer registers right after the displacement, so sampling them at the wrong time is caught there too. A sequencer stuck in the wrong phase shows either as a missing or premature second request, or as a write in the wrong cycle. That shows within one response latency. A byte-order or alternate-select error is visible on the single write cycle. Every vector's expected value differs between its two bytes, so a swap cannot hide.

// File: rtl/ptr_load_pkg.sv
package ptr_load_pkg;
  localparam logic [7:0] PREFIX_BYTE = 8'h6D;
  localparam int unsigned NUM_PTR = 4;
  localparam int unsigned PSEL_W = $clog2(NUM_PTR);

  typedef enum logic [1:0] {DST_BC, DST_DE, DST_IX, DST_IY} dst_e;
  typedef enum logic [1:0] {F_PRE, F_SEL, F_DISP} fstate_e;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_WB} sstate_e;

  typedef struct packed {
    dst_e              dst;
    logic [PSEL_W-1:0] ptr;
    logic [7:0]        disp;
    logic              alt;
  } insn_t;
endpackage

// File: rtl/ptr_load_fetch.sv
module ptr_load_fetch
  import ptr_load_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       fetch_valid_i,
  input  logic [7:0] fetch_byte_i,
  input  logic       alt_i,
  output logic       fetch_ready_o,
  output logic       start_o,
  output insn_t      insn_o,
  output logic       illegal_o
);
  fstate_e    state_q;
  logic [3:0] sel_q;
  logic       illegal_q;
  logic       accept;

  assign fetch_ready_o = !busy_i;
  assign accept        = fetch_valid_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= F_PRE;
      sel_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      if (accept) begin
        case (state_q)
          F_PRE:  if (fetch_byte_i == PREFIX_BYTE) state_q <= F_SEL;
          F_SEL: begin
            if (fetch_byte_i[3:0] != 4'h0) begin
              illegal_q <= 1'b1;
              state_q   <= F_PRE;
            end else begin
              sel_q   <= fetch_byte_i[7:4];
              state_q <= F_DISP;
            end
          end
          F_DISP:  state_q <= F_PRE;
          default: state_q <= F_PRE;
        endcase
      end
    end
  end

  assign start_o     = accept && (state_q == F_DISP);
  assign insn_o.dst  = dst_e'(sel_q[3:2]);
  assign insn_o.ptr  = sel_q[1:0];
  assign insn_o.disp = fetch_byte_i;
  assign insn_o.alt  = alt_i;
  assign illegal_o   = illegal_q;

  // R3
  illegal_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);
  // R3
  illegal_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (state_q == F_PRE) && !start_o);
endmodule

// File: rtl/ptr_load_agen.sv
module ptr_load_agen
  import ptr_load_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned TAG_W    = 16,
  parameter int unsigned NARROW_W = 20,
  parameter int unsigned WIDE_W   = 24
) (
  input  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_file_i,
  input  logic [PSEL_W-1:0]              ptr_sel_i,
  input  logic [7:0]                     disp_i,
  input  logic [ADDR_W-1:0]              acc_addr_i,
  input  logic                           wide_i,
  output logic [ADDR_W-1:0]              ea_o,
  output logic [ADDR_W-1:0]              map_addr_o,
  output logic                           logical_o
);
  localparam logic [ADDR_W-1:0] NARROW_MASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [ADDR_W-1:0] WIDE_MASK   = {{(ADDR_W-WIDE_W){1'b0}}, {WIDE_W{1'b1}}};

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] phys_mask;

  assign disp_ext = {{(ADDR_W-8){disp_i[7]}}, disp_i};
  assign ea_o     = ptr_file_i[ptr_sel_i] + disp_ext;

  assign logical_o  = &acc_addr_i[ADDR_W-1 -: TAG_W];
  assign phys_mask  = wide_i ? WIDE_MASK : NARROW_MASK;
  assign map_addr_o = logical_o ? acc_addr_i : (acc_addr_i & phys_mask);
endmodule

// File: rtl/ptr_load_seq.sv
module ptr_load_seq
  import ptr_load_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  dst_e                dst_i,
  input  logic                alt_i,
  input  logic [ADDR_W-1:0]   ea_i,
  output logic                busy_o,
  output logic [ADDR_W-1:0]   acc_addr_o,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  input  logic                mem_rsp_valid_i,
  input  logic [BYTE_W-1:0]   mem_rsp_data_i,
  output logic                wr_en_o,
  output dst_e                wr_dst_o,
  output logic                wr_alt_o,
  output logic [2*BYTE_W-1:0] wr_data_o,
  output logic                done_o
);
  sstate_e           state_q;
  logic              hi_q;
  logic [ADDR_W-1:0] ea_q;
  dst_e              dst_q;
  logic              alt_q;
  logic [BYTE_W-1:0] lo_byte_q, hi_byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      hi_q      <= 1'b0;
      ea_q      <= '0;
      dst_q     <= DST_BC;
      alt_q     <= 1'b0;
      lo_byte_q <= '0;
      hi_byte_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          ea_q    <= ea_i;
          dst_q   <= dst_i;
          // index destinations never take the alternate copy
          alt_q   <= alt_i && (dst_i inside {DST_BC, DST_DE});
          hi_q    <= 1'b0;
          state_q <= S_REQ;
        end
        S_REQ: if (mem_req_ready_i) state_q <= S_RSP;
        S_RSP: if (mem_rsp_valid_i) begin
          if (!hi_q) begin
            lo_byte_q <= mem_rsp_data_i;
            hi_q      <= 1'b1;
            state_q   <= S_REQ;
          end else begin
            hi_byte_q <= mem_rsp_data_i;
            state_q   <= S_WB;
          end
        end
        S_WB:    state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o          = (state_q != S_IDLE);
  assign acc_addr_o      = ea_q + {{(ADDR_W-1){1'b0}}, hi_q};
  assign mem_req_valid_o = (state_q == S_REQ);
  assign wr_en_o         = (state_q == S_WB);
  assign done_o          = (state_q == S_WB);
  assign wr_dst_o        = dst_q;
  assign wr_alt_o        = alt_q;
  assign wr_data_o       = {hi_byte_q, lo_byte_q};

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(acc_addr_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !wr_en_o);
  // R10
  index_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && (wr_dst_o inside {DST_IX, DST_IY}) |-> !wr_alt_o);
  // R7
  second_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RSP) && mem_rsp_valid_i && !hi_q |=> acc_addr_o == $past(acc_addr_o) + 1);
  // R9
  wb_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(mem_rsp_valid_i));
endmodule

// File: rtl/ptr_load_unit.sv
module ptr_load_unit
  import ptr_load_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned TAG_W    = 16,
  parameter int unsigned NARROW_W = 20,
  parameter int unsigned WIDE_W   = 24
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           fetch_valid_i,
  input  logic [7:0]                     fetch_byte_i,
  output logic                           fetch_ready_o,
  input  logic                           alt_i,
  input  logic                           phys24_i,
  input  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_file_i,
  output logic                           mem_req_valid_o,
  input  logic                           mem_req_ready_i,
  output logic [ADDR_W-1:0]              mem_req_addr_o,
  output logic                           mem_req_xlate_o,
  input  logic                           mem_rsp_valid_i,
  input  logic [7:0]                     mem_rsp_data_i,
  output logic                           wr_en_o,
  output logic [1:0]                     wr_dst_o,
  output logic                           wr_alt_o,
  output logic [15:0]                    wr_data_o,
  output logic                           done_o,
  output logic                           illegal_o
);
  logic              busy, start;
  insn_t             insn;
  logic [ADDR_W-1:0] ea, acc_addr;
  dst_e              dst;

  ptr_load_fetch u_fetch (
    .clk_i, .rst_ni,
    .busy_i        (busy),
    .fetch_valid_i,
    .fetch_byte_i,
    .alt_i,
    .fetch_ready_o,
    .start_o       (start),
    .insn_o        (insn),
    .illegal_o
  );

  ptr_load_agen #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
  ) u_agen (
    .ptr_file_i,
    .ptr_sel_i  (insn.ptr),
    .disp_i     (insn.disp),
    .acc_addr_i (acc_addr),
    .wide_i     (phys24_i),
    .ea_o       (ea),
    .map_addr_o (mem_req_addr_o),
    .logical_o  (mem_req_xlate_o)
  );

  ptr_load_seq #(.ADDR_W(ADDR_W), .BYTE_W(8)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (start),
    .dst_i      (insn.dst),
    .alt_i      (insn.alt),
    .ea_i       (ea),
    .busy_o     (busy),
    .acc_addr_o (acc_addr),
    .mem_req_valid_o,
    .mem_req_ready_i,
    .mem_rsp_valid_i,
    .mem_rsp_data_i,
    .wr_en_o,
    .wr_dst_o   (dst),
    .wr_alt_o,
    .wr_data_o,
    .done_o
  );

  assign wr_dst_o = dst;

  // R5
  xlate_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_xlate_o |-> &mem_req_addr_o[ADDR_W-1 -: TAG_W]);
  // R6
  phys_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_xlate_o |->
      (mem_req_addr_o >> (phys24_i ? WIDE_W : NARROW_W)) == '0);
  // R11
  busy_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !fetch_ready_o);
  // R3
  illegal_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_valid_o && !wr_en_o);
endmodule

// File: tb/ptr_load_unit_tb_top.sv
`timescale 1ns/1ps
module ptr_load_unit_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fetch_valid = 1'b0;
  logic [7:0]        fetch_byte = '0;
  logic              fetch_ready;
  logic              alt = 1'b0, wide = 1'b0;
  logic [3:0][31:0]  ptr_file = '0;
  logic              req_valid, req_ready = 1'b0, req_xlate;
  logic [31:0]       req_addr;
  logic              rsp_valid = 1'b0;
  logic [7:0]        rsp_data = '0;
  logic              wr_en, wr_alt, done, illegal;
  logic [1:0]        wr_dst;
  logic [15:0]       wr_data;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  ptr_load_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_byte_i(fetch_byte), .fetch_ready_o(fetch_ready),
    .alt_i(alt), .phys24_i(wide), .ptr_file_i(ptr_file),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
    .mem_req_addr_o(req_addr), .mem_req_xlate_o(req_xlate),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .wr_en_o(wr_en), .wr_dst_o(wr_dst), .wr_alt_o(wr_alt), .wr_data_o(wr_data),
    .done_o(done), .illegal_o(illegal)
  );

  typedef struct packed {
    logic [31:0] ptr;
    logic [3:0]  sel;
    logic [7:0]  disp;
    logic        alt;
    logic        wide;
    logic [1:0]  stall;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0001_2340, 4'h0, 8'h05, 1'b0, 1'b0, 2'd0},
    '{32'hFFFF_1000, 4'h5, 8'hF0, 1'b1, 1'b0, 2'd2},
    '{32'h1234_5678, 4'hA, 8'h10, 1'b1, 1'b1, 2'd0},
    '{32'hFFFF_FFFF, 4'hF, 8'h00, 1'b1, 1'b0, 2'd1},
    '{32'hFFFE_FFFF, 4'h3, 8'h01, 1'b1, 1'b1, 2'd0},
    '{32'h00F0_FFFF, 4'h6, 8'h80, 1'b0, 1'b0, 2'd3},
    '{32'h0000_0080, 4'h9, 8'h80, 1'b0, 1'b1, 2'd0},
    '{32'hFFFF_FFFE, 4'hC, 8'h7F, 1'b1, 1'b0, 2'd1}
  };

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C ^ {a[0], 7'h00};
  endfunction

  function automatic logic is_log(logic [31:0] a);
    return a[31:16] == 16'hFFFF;
  endfunction

  function automatic logic [31:0] exp_map(logic [31:0] a, logic w);
    if (is_log(a)) return a;
    return w ? (a & 32'h00FF_FFFF) : (a & 32'h000F_FFFF);
  endfunction

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      finish_run();
    end
  end

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    fetch_valid = 1'b1;
    fetch_byte  = b;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic serve(logic [31:0] exp_a, logic exp_x, int stall, string tag);
    logic [31:0] a;
    while (!req_valid) @(negedge clk);
    a = req_addr;
    check_eq(exp_x ? "R5" : "R6", {tag, " addr"}, req_addr, exp_a);
    check_eq(exp_x ? "R5" : "R6", {tag, " xlate"}, {31'b0, req_xlate}, {31'b0, exp_x});
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check_eq("R8", {tag, " held"}, {req_xlate, req_valid, req_addr[29:0]}, {exp_x, 1'b1, a[29:0]});
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check_eq("R7", {tag, " one outstanding"}, {31'b0, req_valid}, 32'd0);
    check_eq("R11", {tag, " fetch blocked"}, {31'b0, fetch_ready}, 32'd0);
    rsp_valid = 1'b1;
    rsp_data  = mem_byte(a);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic run_vec(vec_t v);
    logic [31:0] ea, ea1;
    for (int k = 0; k < 4; k++) ptr_file[k] = 32'h0A5A_0000 + 32'(k) * 32'h1111;
    ptr_file[v.sel[1:0]] = v.ptr;
    alt  = v.alt;
    wide = v.wide;
    ea  = v.ptr + {{24{v.disp[7]}}, v.disp};
    ea1 = ea + 32'd1;
    send_byte(8'h6D);
    send_byte({v.sel, 4'h0});
    send_byte(v.disp);
    // R4: pointer and modifier sampled with the displacement only
    ptr_file[v.sel[1:0]] = ~v.ptr;
    alt = ~v.alt;
    serve(exp_map(ea, v.wide), is_log(ea), int'(v.stall), "R4 lo");
    serve(exp_map(ea1, v.wide), is_log(ea1), 0, "R7 hi");
    check_eq("R9", "wr_en", {31'b0, wr_en}, 32'd1);
    check_eq("R9", "done", {31'b0, done}, 32'd1);
    check_eq("R9", "data",
             {16'b0, wr_data}, {16'b0, mem_byte(exp_map(ea1, v.wide)), mem_byte(exp_map(ea, v.wide))});
    check_eq("R2", "dst", {30'b0, wr_dst}, {30'b0, v.sel[3:2]});
    check_eq("R10", "alt", {31'b0, wr_alt}, {31'b0, v.alt & ~v.sel[3]});
    @(negedge clk);
    check_eq("R9", "single cycle", {30'b0, wr_en, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R12", "in reset", {28'b0, req_valid, wr_en, illegal, fetch_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R12", "after reset", {27'b0, req_valid, wr_en, done, illegal, fetch_ready}, 32'd1);

    // R11: stray response while idle
    rsp_valid = 1'b1; rsp_data = 8'hEE;
    @(negedge clk);
    rsp_valid = 1'b0;
    @(negedge clk);
    check_eq("R11", "stray rsp", {30'b0, wr_en, req_valid}, 32'd0);

    // R1: junk bytes before the prefix
    send_byte(8'h00);
    check_eq("R1", "junk 00", {31'b0, illegal}, 32'd0);
    send_byte(8'h6C);
    check_eq("R1", "junk 6C", {30'b0, illegal, req_valid}, 32'd0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R3: illegal selector
    send_byte(8'h6D);
    send_byte(8'h48);
    check_eq("R3", "illegal pulse", {31'b0, illegal}, 32'd1);
    @(negedge clk);
    check_eq("R3", "illegal clears", {31'b0, illegal}, 32'd0);
    send_byte(8'h05);
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      check_eq("R3", "no request", {30'b0, req_valid, illegal}, 32'd0);
    end
    run_vec(VECS[3]);
    run_vec(VECS[0]);
    finish_run();
  end
endmodule